// File: doc/BRIEF.md
# Matrix Keypad Scanner with Key-Code Queue

This block drives the scan lines of a key matrix and watches eight active-low return lines for a closure. A closure is accepted only after the same key has been seen on two complete scan passes in a row. The accepted key is turned into an eight-bit code that also records the levels of the SHIFT and CONTROL inputs, and the code is placed in an eight-entry first-in first-out queue. An interrupt request is raised while the queue holds codes. If a code arrives while the queue is full, the code is dropped and a sticky overrun flag is set.

The scan lines run in one of two modes. In binary mode the scan outputs carry a 3-bit row number that an external decoder turns into eight rows, so the matrix can be 8x8. In one-hot mode the four outputs drive four rows directly, so the matrix is 4x8. A prescaler sets how many clock cycles each row stays active. A small CPU-side port reads the status word and the queue head, and takes command writes that select the scan mode and clear the overrun flag.

Top module: `kpd_ctrl`

## Requirements
- R1: In binary mode (mode bit 0 = 0), scan_out[2:0] holds the row number and counts 0,1,...,7 and then wraps. It advances by one every PRESCALE clock cycles, and scan_out[3] is 0.
- R2: In one-hot mode (mode bit 0 = 1), scan_out has exactly one bit high, at the position of the row (0 to 3). The high bit moves up one position every PRESCALE cycles and wraps from bit 3 to bit 0.
- R3: A key code is {CONTROL level in bit 7, SHIFT level in bit 6, row in bits 5:3, column in bits 2:0}. The column is the index of the lowest return line that reads 0 while that row is scanned.
- R4: A key is entered only after it has been seen on two consecutive full scan passes. A press shorter than one pass creates no entry.
- R5: A held key creates exactly one entry. No further entry is made, even for a second key pressed meanwhile, until a full scan pass finds no key down.
- R6: Codes leave the queue in the order they were entered, and the queue holds up to 8 codes.
- R7: A code that arrives while the queue holds 8 entries is dropped and sets the overrun flag. The flag stays set until a command write with bit 1 = 1.
- R8: irq is high while the queue is not empty. It is low in the cycle after each data read, and high again one cycle later if codes remain.
- R9: A status read (bus_sel = 1) returns the entry count in bits 3:0, the queue-full flag in bit 5, the overrun flag in bit 6, and 0 in the other bits.
- R10: After reset the queue is empty, irq is 0, overrun is 0, binary mode is selected and scan_out is 0.
- R11: A data read (bus_sel = 0) of an empty queue leaves the count, the flags and irq unchanged.
- R12: A command write (bus_wr with bus_sel = 1) sets the mode from bit 0. A change of mode restarts the scan at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | 1 selects status read or command write, 0 selects a data read |
| bus_rd | input | 1 | Read strobe, one cycle; a data read removes the queue head |
| bus_wr | input | 1 | Command write strobe, one cycle |
| bus_wdata | input | 8 | Command: bit 0 selects the mode, bit 1 clears overrun |
| bus_rdata | output | 8 | Status word or queue head, selected by bus_sel |
| scan_out | output | 4 | Scan lines: a binary row number or a one-hot row |
| ret_n | input | 8 | Return lines, low where a key on the active row is pressed |
| shift_in | input | 1 | SHIFT level, stored with each code |
| ctrl_in | input | 1 | CONTROL level, stored with each code |
| irq | output | 1 | Interrupt request |

## Verification
The scan assertions assume that the mode changes only through the command write, which also restarts the scan in that cycle. The queue assertions assume that a read strobe lasts a single cycle. The bench keeps within these limits: it changes the mode only while no key is down, and it pulses bus_rd and bus_wr for exactly one cycle. The return lines are modelled as a key matrix driven from scan_out, so a pressed key pulls its column low only while its row is being scanned. Key presses and releases are spaced by whole scan passes, so each debounce decision depends on the intended sequence of events and not on where the scan happens to be when a key changes.

// File: rtl/kpd_pkg.sv
`timescale 1ns/1ps
package kpd_pkg;
    localparam int ROW_W  = 3;
    localparam int COLS   = 8;
    localparam int COL_W  = $clog2(COLS);

    typedef struct packed {
        logic             ctrl;
        logic             shift;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } key_code_t;

    localparam int CODE_W = $bits(key_code_t);
endpackage

// File: rtl/kpd_scan.sv
`timescale 1ns/1ps
module kpd_scan #(
    parameter int PRESCALE = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      dec_mode,
    output logic                      tick,
    output logic [kpd_pkg::ROW_W-1:0] row,
    output logic                      last_row,
    output logic [3:0]                scan_out
);
    import kpd_pkg::*;
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [ROW_W-1:0] row;
    } scan_st_t;

    scan_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.pre == PW'(PRESCALE - 1));
        last_row = dec_mode ? (st_q.row[1:0] == 2'd3) : (st_q.row == '1);
        if (restart) begin
            st_d.pre = '0;
            st_d.row = '0;
        end else if (tick) begin
            st_d.pre = '0;
            if (dec_mode) st_d.row = {1'b0, st_q.row[1:0] + 2'd1};
            else          st_d.row = st_q.row + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row      = st_q.row;
    assign scan_out = dec_mode ? (4'b0001 << st_q.row[1:0]) : {1'b0, st_q.row};

    AST_ENC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !restart && !dec_mode |=> scan_out[2:0] == $past(scan_out[2:0]) + 3'd1); // R1
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !restart |=> $stable(scan_out)); // R1
    AST_DEC_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !restart && dec_mode |=> scan_out == {$past(scan_out[2:0]), $past(scan_out[3])}); // R2
endmodule

// File: rtl/kpd_debounce.sv
`timescale 1ns/1ps
module kpd_debounce (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      tick,
    input  logic [kpd_pkg::ROW_W-1:0] row,
    input  logic                      last_row,
    input  logic [kpd_pkg::COLS-1:0]  ret_n,
    input  logic                      shift_in,
    input  logic                      ctrl_in,
    output logic                      push,
    output kpd_pkg::key_code_t        push_code
);
    import kpd_pkg::*;

    typedef struct packed {
        logic      found;
        key_code_t key;
        logic      cand_vld;
        key_code_t cand;
        logic      locked;
        logic      push;
        key_code_t code;
    } deb_st_t;

    deb_st_t st_q, st_d;

    always_comb begin
        logic             hit;
        logic [COL_W-1:0] col;
        logic             f;
        key_code_t        k;
        st_d      = st_q;
        st_d.push = 1'b0;
        hit = ~&ret_n;
        col = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (!ret_n[i]) col = COL_W'(i);
        end
        f = st_q.found;
        k = st_q.key;
        if (restart) begin
            st_d = '0;
        end else if (tick) begin
            if (hit && !f) begin
                f = 1'b1;
                k = '{ctrl: ctrl_in, shift: shift_in, row: row, col: col};
            end
            if (last_row) begin
                st_d.found = 1'b0;
                if (!f) begin
                    st_d.locked   = 1'b0;
                    st_d.cand_vld = 1'b0;
                end else if (!st_q.locked) begin
                    if (st_q.cand_vld && st_q.cand.row == k.row && st_q.cand.col == k.col) begin
                        st_d.push     = 1'b1;
                        st_d.code     = k;
                        st_d.locked   = 1'b1;
                        st_d.cand_vld = 1'b0;
                    end else begin
                        st_d.cand     = k;
                        st_d.cand_vld = 1'b1;
                    end
                end
            end else begin
                st_d.found = f;
                st_d.key   = k;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push      = st_q.push;
    assign push_code = st_q.code;

    AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R5
    AST_PUSH_AFTER_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push) |-> $past(st_q.cand_vld)); // R4
    AST_LOCKED_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked && !restart |=> !push); // R5
endmodule

// File: rtl/kpd_fifo.sv
`timescale 1ns/1ps
module kpd_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop_req,
    input  logic          clr_ovr,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          overrun,
    output logic          irq
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic                    ovr;
        logic                    irq;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic     pop, wr;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        full = (st_q.cnt == CW'(DEPTH));
        pop  = pop_req && (st_q.cnt != '0);
        wr   = push && (!full || pop);
        if (wr) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp           = nxt(st_q.wp);
        end
        if (pop) st_d.rp = nxt(st_q.rp);
        st_d.cnt = st_q.cnt + CW'(wr) - CW'(pop);
        if (clr_ovr) st_d.ovr = 1'b0;
        if (push && full && !pop) st_d.ovr = 1'b1;
        st_d.irq = (st_d.cnt != '0) && !pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head    = st_q.mem[st_q.rp];
    assign count   = st_q.cnt;
    assign overrun = st_q.ovr;
    assign irq     = st_q.irq;

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop_req |=> count == CW'(DEPTH) && overrun); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !clr_ovr |=> overrun); // R7
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !irq); // R8
    AST_IRQ_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req && count != '0 |=> irq); // R8
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && count == '0 && !push |=> count == '0 && !irq); // R11
endmodule

// File: rtl/kpd_ctrl.sv
`timescale 1ns/1ps
module kpd_ctrl #(
    parameter int PRESCALE   = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [3:0] scan_out,
    input  logic [7:0] ret_n,
    input  logic       shift_in,
    input  logic       ctrl_in,
    output logic       irq
);
    import kpd_pkg::*;
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic dec;
    } mode_st_t;

    mode_st_t  mode_q, mode_d;
    logic      cmd_wr, restart, clr_ovr, pop_req;
    logic      tick, last_row, push, full, overrun;
    logic [ROW_W-1:0] row;
    key_code_t code, head;
    logic [CW-1:0] count;
    logic [7:0] status;

    always_comb begin
        mode_d  = mode_q;
        cmd_wr  = bus_wr && bus_sel;
        restart = cmd_wr && (bus_wdata[0] != mode_q.dec);
        clr_ovr = cmd_wr && bus_wdata[1];
        pop_req = bus_rd && !bus_sel;
        if (cmd_wr) mode_d.dec = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    kpd_scan #(.PRESCALE(PRESCALE)) u_scan (
        .clk(clk), .rst_n(rst_n), .restart(restart), .dec_mode(mode_q.dec),
        .tick(tick), .row(row), .last_row(last_row), .scan_out(scan_out)
    );

    kpd_debounce u_deb (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .row(row),
        .last_row(last_row), .ret_n(ret_n), .shift_in(shift_in), .ctrl_in(ctrl_in),
        .push(push), .push_code(code)
    );

    kpd_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(code), .pop_req(pop_req),
        .clr_ovr(clr_ovr), .head(head), .count(count), .full(full),
        .overrun(overrun), .irq(irq)
    );

    assign status    = {1'b0, overrun, full, 1'b0, 4'(count)};
    assign bus_rdata = bus_sel ? status : head;

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (mode_q.dec ? scan_out == 4'b0001 : scan_out == 4'b0000)); // R12
endmodule

// File: tb/tb_kpd_ctrl.sv
`timescale 1ns/1ps
module tb_kpd_ctrl;
    localparam int PS = 4;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic [3:0] scan_out;
    logic [7:0] ret_n;
    logic shift_in = 1'b1, ctrl_in = 1'b1, irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic tb_dec = 1'b0;
    logic pa = 1'b0, pb = 1'b0;
    logic [2:0] ra = 0, ca = 0, rb = 0, cb = 0;
    logic [2:0] cur_row;

    always #2 clk = ~clk;

    kpd_ctrl #(.PRESCALE(PS), .FIFO_DEPTH(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scan_out(scan_out), .ret_n(ret_n),
        .shift_in(shift_in), .ctrl_in(ctrl_in), .irq(irq)
    );

    always_comb begin
        if (tb_dec) cur_row = scan_out[0] ? 3'd0 : scan_out[1] ? 3'd1 : scan_out[2] ? 3'd2 : 3'd3;
        else        cur_row = scan_out[2:0];
    end
    assign ret_n = ~(({8{pa && cur_row == ra}} & (8'd1 << ca)) |
                     ({8{pb && cur_row == rb}} & (8'd1 << cb)));

    // table: {mode, row, col, shift, ctrl}
    localparam logic [8:0] VEC [7] = '{
        {1'b0, 3'd0, 3'd0, 1'b1, 1'b1},
        {1'b0, 3'd7, 3'd7, 1'b0, 1'b1},
        {1'b0, 3'd5, 3'd2, 1'b1, 1'b0},
        {1'b0, 3'd3, 3'd6, 1'b0, 1'b0},
        {1'b1, 3'd3, 3'd7, 1'b1, 1'b1},
        {1'b1, 3'd0, 3'd4, 1'b0, 1'b1},
        {1'b1, 3'd2, 3'd1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic sel, output logic [7:0] data);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        do_write({6'd0, 1'b0, m});
        tb_dec = m;
        repeat (80) @(negedge clk);
    endtask

    task automatic wait_count(input int n, output bit ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int t = 0; t < 300; t++) begin
            do_read(1'b1, s);
            if (s[3:0] == 4'(n)) begin ok = 1'b1; break; end
        end
    endtask

    task automatic press(input logic [2:0] r, input logic [2:0] c, input logic s, input logic k);
        @(negedge clk);
        ra = r; ca = c; shift_in = s; ctrl_in = k; pa = 1'b1;
    endtask

    task automatic release_all();
        @(negedge clk);
        pa = 1'b0; pb = 1'b0; shift_in = 1'b1; ctrl_in = 1'b1;
        repeat (100) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, s0;
        bit ok;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 scan", {28'd0, scan_out}, 0);
        check("R10 irq", {31'd0, irq}, 0);
        do_read(1'b1, d);
        check("R10 status", {24'd0, d}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 binary scan
        for (int i = 0; i < 10; i++) begin
            s0 = {4'd0, scan_out};
            repeat (PS) @(negedge clk);
            check("R1 step", {28'd0, scan_out}, {29'd0, s0[2:0] + 3'd1});
        end
        // R12 mode change restarts, R2 one-hot scan
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0; tb_dec = 1'b1;
        check("R12 restart", {28'd0, scan_out}, 32'h1);
        for (int i = 0; i < 6; i++) begin
            s0 = {4'd0, scan_out};
            repeat (PS) @(negedge clk);
            check("R2 rotate", {28'd0, scan_out}, {28'd0, s0[2:0], s0[3]});
            check("R2 onehot", $countones(scan_out), 1);
        end
        set_mode(1'b0);

        // table walk: R3 code format, R8 irq, R9 status
        for (int i = 0; i < 7; i++) begin
            logic [7:0] exp;
            if (VEC[i][8] != tb_dec) set_mode(VEC[i][8]);
            exp = {VEC[i][0], VEC[i][1], VEC[i][7:5], VEC[i][4:2]};
            press(VEC[i][7:5], VEC[i][4:2], VEC[i][1], VEC[i][0]);
            wait_count(1, ok);
            check("R3 entered", {31'd0, ok}, 1);
            check("R8 irq high", {31'd0, irq}, 1);
            do_read(1'b1, d);
            check("R9 status one", {24'd0, d}, 32'h01);
            do_read(1'b0, d);
            check("R3 code", {24'd0, d}, {24'd0, exp});
            check("R8 irq drop", {31'd0, irq}, 0);
            @(negedge clk);
            check("R8 irq stays low", {31'd0, irq}, 0);
            release_all();
        end
        set_mode(1'b0);

        // R4 short press
        press(3'd5, 3'd2, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        release_all();
        repeat (100) @(negedge clk);
        do_read(1'b1, d);
        check("R4 short press ignored", {24'd0, d}, 0);
        check("R4 irq", {31'd0, irq}, 0);

        // R5 held key, second key while held
        press(3'd1, 3'd3, 1'b1, 1'b1);
        repeat (300) @(negedge clk);
        do_read(1'b1, d);
        check("R5 one entry held", {24'd0, d}, 32'h01);
        @(negedge clk);
        rb = 3'd6; cb = 3'd0; pb = 1'b1;
        repeat (300) @(negedge clk);
        do_read(1'b1, d);
        check("R5 no second entry", {24'd0, d}, 32'h01);
        release_all();
        do_read(1'b0, d);
        check("R5 code", {24'd0, d}, 32'hCB);

        // R11 empty read
        do_read(1'b0, d);
        do_read(1'b1, d);
        check("R11 empty read count", {24'd0, d}, 0);
        check("R11 irq", {31'd0, irq}, 0);

        // R6/R7 fill and overrun
        for (int k = 0; k < 8; k++) begin
            press(3'(k), 3'(k * 3), k[0], k[1]);
            wait_count(k + 1, ok);
            check("R6 fill", {31'd0, ok}, 1);
            release_all();
        end
        do_read(1'b1, d);
        check("R9 full status", {24'd0, d}, 32'h28);
        press(3'd4, 3'd5, 1'b1, 1'b1);
        repeat (250) @(negedge clk);
        release_all();
        do_read(1'b1, d);
        check("R7 overrun status", {24'd0, d}, 32'h68);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] exp;
            logic [2:0] kr, kc;
            kr = 3'(k); kc = 3'(k * 3);
            exp = {k[1], k[0], kr, kc};
            do_read(1'b0, d);
            check("R6 order", {24'd0, d}, {24'd0, exp});
            check("R8 drop", {31'd0, irq}, 0);
            @(negedge clk);
            check("R8 rearm", {31'd0, irq}, (k < 7) ? 1 : 0);
        end
        do_read(1'b1, d);
        check("R7 sticky", {24'd0, d}, 32'h40);
        do_write(8'h02);
        do_read(1'b1, d);
        check("R7 cleared", {24'd0, d}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule